// File: doc/BRIEF.md
# USB Full-Speed Line-State Monitor

This block watches the full-speed data lines of a USB device port. The receiver has already reduced the lines to three one-hot line states: idle J, K, and single-ended zero. The monitor samples them on a bit-rate clock enable. It counts how long each condition lasts, in bit times, and from that decides whether the host is resetting the port, whether the bus has gone quiet long enough to count as suspend, and whether activity has come back after a suspend. It also times the gap between a transmitted packet and the host's reply, and flags a timeout when no reply starts in time.

Each detection sets a status bit and raises a single bus-event flag. Software clears the flag by writing one to it. With the flag raised, the four status bits tell software which condition occurred. The interrupt line is the flag gated by its enable. Two register-driven overrides also control the transceiver drive: a remote wake-up request holds the lines in K, and a forced single-ended zero pulls both lines low.

The default thresholds assume a 12 MHz bit-enable rate. A reset needs 30 bit times of SE0 (2.5 µs), a suspend needs 36000 bit times of idle (3 ms), and a timeout needs 18 bit times without a reply.

Top module: `usb_linestate_mon`

## Requirements
- R1: While `rst_n` is low, or on any cycle in which `ctl_enable` is low, all run counters and the reply timer clear, and every status bit and `bus_evt` read 0 on the following cycle.
- R2: `st_reset` rises at the clock edge of the `RST_BITS`-th consecutive bit tick that sees `line_se0`. It falls at the first bit tick without `line_se0`.
- R3: `st_suspend` rises at the clock edge of the `SUSP_BITS`-th consecutive bit tick that sees `line_j`. It falls at the first bit tick without `line_j`.
- R4: A bit tick without `line_j` while `st_suspend` is set sets `st_resume`. `st_resume` then stays set until it is cleared through `evt_clr`.
- R5: A pulse on `resp_arm` starts the reply timer from zero, and restarts it if it is already running. A bit tick with `line_k` stops the timer. If `TOUT_BITS` bit ticks pass without `line_k`, `st_timeout` is set and stays set until it is cleared through `evt_clr`.
- R6: `bus_evt` is set by a rise of `st_reset`, by suspend entry, by resume, and by timeout. `evt_clr` clears `bus_evt`, `st_resume` and `st_timeout`. When an event and `evt_clr` fall in the same cycle, the event wins.
- R7: `irq` is 1 exactly when `bus_evt` and `int_en` are both 1.
- R8: With `rwake_req` set and `force_se0` clear, the outputs drive K: `drv_oe`=1, `drv_dp`=0, `drv_dm`=1.
- R9: With `force_se0` set, the outputs drive SE0 (`drv_oe`=1, `drv_dp`=0, `drv_dm`=0), whatever `rwake_req` is. With neither override set, all three drive outputs are 0.
- R10: A cycle with `bit_en` low leaves `st_reset`, `st_suspend`, `st_resume` and `st_timeout` unchanged, except for the clearing done by `evt_clr` and `ctl_enable`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One-cycle bit-time tick |
| line_j | input | 1 | Sampled line is in idle J state |
| line_k | input | 1 | Sampled line is in K state |
| line_se0 | input | 1 | Sampled line is single-ended zero |
| ctl_enable | input | 1 | Monitor enable |
| resp_arm | input | 1 | Pulse: start waiting for a host reply |
| rwake_req | input | 1 | Remote wake-up: hold lines in K |
| force_se0 | input | 1 | Hold both lines low |
| int_en | input | 1 | Bus-event interrupt enable |
| evt_clr | input | 1 | Write-one pulse clearing the event flag |
| st_reset | output | 1 | Bus reset present |
| st_suspend | output | 1 | Bus suspended |
| st_resume | output | 1 | Resume seen (sticky) |
| st_timeout | output | 1 | Reply timeout seen (sticky) |
| bus_evt | output | 1 | Bus-event flag |
| irq | output | 1 | Bus-event interrupt |
| drv_oe | output | 1 | Transceiver drive enable |
| drv_dp | output | 1 | Driven D+ value |
| drv_dm | output | 1 | Driven D- value |

## Verification
The case most likely to hide a bug is software's write-one clear landing in the same cycle as a new bus event. This happens for a resume, a timeout expiry or a reset detection. If clear has priority, the new event is silently lost. The bench builds this case directly: it arms the reply timer, counts off exactly one bit tick short of the limit, then applies the expiring tick together with `evt_clr`, and expects both `bus_evt` and `st_timeout` to read 1. The random phase keeps issuing clear pulses while line-state segments of random length produce resets, suspends and resumes, so many more such collisions occur, each judged against the bench's own model.

// File: rtl/lm_pkg.sv
package lm_pkg;

  typedef struct packed {
    logic oe;
    logic dp;
    logic dm;
  } lm_drive_t;

  // Override selection: SE0 has priority over the wake-up K state.
  function automatic lm_drive_t lm_drive_sel(input logic se0_req, input logic wake_req);
    lm_drive_t d;
    if (se0_req) begin
      d = '{oe: 1'b1, dp: 1'b0, dm: 1'b0};
    end else if (wake_req) begin
      d = '{oe: 1'b1, dp: 1'b0, dm: 1'b1};
    end else begin
      d = '{oe: 1'b0, dp: 1'b0, dm: 1'b0};
    end
    return d;
  endfunction

  // Width that can hold the values 0..limit.
  function automatic int unsigned lm_cnt_w(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/lm_runlen.sv
module lm_runlen #(
  parameter int unsigned LIMIT = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic cond,
  output logic hit
);
  localparam int unsigned W = lm_pkg::lm_cnt_w(LIMIT);

  logic [W-1:0] run_q;

  // Hit marks the tick that completes LIMIT consecutive samples of cond.
  assign hit = en && tick && cond && (run_q == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!en) begin
      run_q <= '0;
    end else if (tick) begin
      if (!cond) begin
        run_q <= '0;
      end else if (run_q != W'(LIMIT)) begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lm_resp_timer.sv
module lm_resp_timer #(
  parameter int unsigned LIMIT = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic arm,
  input  logic got_k,
  output logic expire
);
  localparam int unsigned W = lm_pkg::lm_cnt_w(LIMIT);

  logic         wait_q;
  logic [W-1:0] cnt_q;

  assign expire = en && tick && wait_q && !arm && !got_k && (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!en) begin
      wait_q <= 1'b0;
      cnt_q  <= '0;
    end else if (arm) begin
      wait_q <= 1'b1;
      cnt_q  <= '0;
    end else if (tick && wait_q) begin
      if (got_k || expire) begin
        wait_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lm_drive.sv
module lm_drive (
  input  logic rwake_req,
  input  logic force_se0,
  output logic drv_oe,
  output logic drv_dp,
  output logic drv_dm
);
  lm_pkg::lm_drive_t sel;

  always_comb begin
    sel    = lm_pkg::lm_drive_sel(force_se0, rwake_req);
    drv_oe = sel.oe;
    drv_dp = sel.dp;
    drv_dm = sel.dm;
  end
endmodule

// File: rtl/usb_linestate_mon.sv
module usb_linestate_mon #(
  parameter int unsigned RST_BITS  = 30,
  parameter int unsigned SUSP_BITS = 36000,
  parameter int unsigned TOUT_BITS = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic line_j,
  input  logic line_k,
  input  logic line_se0,
  input  logic ctl_enable,
  input  logic resp_arm,
  input  logic rwake_req,
  input  logic force_se0,
  input  logic int_en,
  input  logic evt_clr,
  output logic st_reset,
  output logic st_suspend,
  output logic st_resume,
  output logic st_timeout,
  output logic bus_evt,
  output logic irq,
  output logic drv_oe,
  output logic drv_dp,
  output logic drv_dm
);
  // Named internal events, exposed for the checker.
  logic ev_reset;
  logic ev_suspend;
  logic ev_resume;
  logic ev_timeout;
  logic any_evt;
  logic tick_on;

  assign tick_on = ctl_enable && bit_en;

  lm_runlen #(.LIMIT(RST_BITS)) u_se0_run (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (ctl_enable),
    .tick (bit_en),
    .cond (line_se0),
    .hit  (ev_reset)
  );

  lm_runlen #(.LIMIT(SUSP_BITS)) u_idle_run (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (ctl_enable),
    .tick (bit_en),
    .cond (line_j),
    .hit  (ev_suspend)
  );

  lm_resp_timer #(.LIMIT(TOUT_BITS)) u_resp (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ctl_enable),
    .tick  (bit_en),
    .arm   (resp_arm),
    .got_k (line_k),
    .expire(ev_timeout)
  );

  lm_drive u_drive (
    .rwake_req(rwake_req),
    .force_se0(force_se0),
    .drv_oe   (drv_oe),
    .drv_dp   (drv_dp),
    .drv_dm   (drv_dm)
  );

  assign ev_resume = tick_on && !line_j && st_suspend;
  assign any_evt   = ev_reset || ev_suspend || ev_resume || ev_timeout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_reset   <= 1'b0;
      st_suspend <= 1'b0;
      st_resume  <= 1'b0;
      st_timeout <= 1'b0;
      bus_evt    <= 1'b0;
    end else if (!ctl_enable) begin
      st_reset   <= 1'b0;
      st_suspend <= 1'b0;
      st_resume  <= 1'b0;
      st_timeout <= 1'b0;
      bus_evt    <= 1'b0;
    end else begin
      if (ev_reset)                   st_reset <= 1'b1;
      else if (bit_en && !line_se0)   st_reset <= 1'b0;

      if (ev_suspend)                 st_suspend <= 1'b1;
      else if (bit_en && !line_j)     st_suspend <= 1'b0;

      // Set has priority over the software clear.
      if (ev_resume)                  st_resume <= 1'b1;
      else if (evt_clr)               st_resume <= 1'b0;

      if (ev_timeout)                 st_timeout <= 1'b1;
      else if (evt_clr)               st_timeout <= 1'b0;

      if (any_evt)                    bus_evt <= 1'b1;
      else if (evt_clr)               bus_evt <= 1'b0;
    end
  end

  assign irq = bus_evt && int_en;
endmodule

// File: rtl/lm_checks.sv
module lm_checks (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic line_j,
  input logic line_k,
  input logic line_se0,
  input logic ctl_enable,
  input logic rwake_req,
  input logic force_se0,
  input logic evt_clr,
  input logic st_reset,
  input logic st_suspend,
  input logic st_resume,
  input logic st_timeout,
  input logic bus_evt,
  input logic any_evt,
  input logic drv_oe,
  input logic drv_dp,
  input logic drv_dm
);
  assert_disable_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |=> !st_reset && !st_suspend && !st_resume && !st_timeout && !bus_evt);

  assert_reset_needs_se0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_reset) |-> $past(line_se0 && bit_en));

  assert_suspend_needs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_suspend) |-> $past(line_j && bit_en));

  assert_resume_after_suspend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_resume) |-> $past(st_suspend));

  assert_timeout_no_k_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_timeout) |-> $past(bit_en && !line_k));

  assert_event_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> bus_evt);

  assert_clear_drops_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && !any_evt) |=> !bus_evt);

  assert_wake_drives_k_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rwake_req && !force_se0) |-> (drv_oe && !drv_dp && drv_dm));

  assert_se0_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_se0 |-> (drv_oe && !drv_dp && !drv_dm));

  assert_no_tick_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && ctl_enable) |=> ($stable(st_reset) && $stable(st_suspend)));
endmodule

bind usb_linestate_mon lm_checks u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .line_j    (line_j),
  .line_k    (line_k),
  .line_se0  (line_se0),
  .ctl_enable(ctl_enable),
  .rwake_req (rwake_req),
  .force_se0 (force_se0),
  .evt_clr   (evt_clr),
  .st_reset  (st_reset),
  .st_suspend(st_suspend),
  .st_resume (st_resume),
  .st_timeout(st_timeout),
  .bus_evt   (bus_evt),
  .any_evt   (any_evt),
  .drv_oe    (drv_oe),
  .drv_dp    (drv_dp),
  .drv_dm    (drv_dm)
);

// File: tb/sim_usb_linestate_mon.sv
`timescale 1ns/1ps
module sim_usb_linestate_mon;
  localparam int RST_B  = 6;
  localparam int SUSP_B = 40;
  localparam int TOUT_B = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 0, line_j = 0, line_k = 0, line_se0 = 0;
  logic ctl_enable = 0, resp_arm = 0, rwake_req = 0, force_se0 = 0, int_en = 0, evt_clr = 0;
  logic st_reset, st_suspend, st_resume, st_timeout, bus_evt, irq, drv_oe, drv_dp, drv_dm;

  always #2.5 clk = ~clk;

  usb_linestate_mon #(.RST_BITS(RST_B), .SUSP_BITS(SUSP_B), .TOUT_BITS(TOUT_B)) u0 (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;

  // Bench model state
  int m_se0run, m_jrun, m_wrun;
  bit m_wait, m_rst, m_susp, m_res, m_to, m_evt;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit [2:0] exp_drive(input bit se0, input bit wake);
    if (se0) return 3'b100;
    if (wake) return 3'b101;
    return 3'b000;
  endfunction

  task automatic model_clear();
    m_se0run = 0; m_jrun = 0; m_wrun = 0;
    {m_wait, m_rst, m_susp, m_res, m_to, m_evt} = '0;
  endtask

  task automatic model_step();
    bit ev;
    bit was_susp;
    ev = 0;
    if (!ctl_enable) begin
      model_clear();
      return;
    end
    if (evt_clr) begin m_res = 0; m_to = 0; m_evt = 0; end
    was_susp = m_susp;
    if (bit_en) begin
      if (line_se0) begin
        m_se0run++;
        if (m_se0run == RST_B) begin m_rst = 1; ev = 1; end
      end else begin
        m_se0run = 0; m_rst = 0;
      end
      if (line_j) begin
        m_jrun++;
        if (m_jrun == SUSP_B) begin m_susp = 1; ev = 1; end
      end else begin
        m_jrun = 0;
        if (was_susp) begin m_susp = 0; m_res = 1; ev = 1; end
      end
    end
    if (resp_arm) begin
      m_wait = 1; m_wrun = 0;
    end else if (bit_en && m_wait) begin
      if (line_k) m_wait = 0;
      else begin
        m_wrun++;
        if (m_wrun == TOUT_B) begin m_to = 1; ev = 1; m_wait = 0; end
      end
    end
    if (ev) m_evt = 1;
  endtask

  task automatic compare();
    bit [2:0] d;
    d = exp_drive(force_se0, rwake_req);
    chk("R2 st_reset", st_reset, m_rst);
    chk("R3 st_suspend", st_suspend, m_susp);
    chk("R4 st_resume", st_resume, m_res);
    chk("R5 st_timeout", st_timeout, m_to);
    chk("R6 bus_evt", bus_evt, m_evt);
    chk("R7 irq", irq, m_evt & int_en);
    chk("R8/R9 drive", {drv_oe, drv_dp, drv_dm}, d);
  endtask

  // One clock: inputs already set; advance model at the edge, compare after.
  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic set_line(input int s);
    line_j = (s == 0); line_k = (s == 1); line_se0 = (s == 2);
  endtask

  task automatic ticks(input int s, input int n);
    set_line(s); bit_en = 1;
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin : main
    void'($urandom(32'h1234_abcd));
    model_clear();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset st_reset", st_reset, 0);
    chk("R1 reset bus_evt", bus_evt, 0);
    chk("R1 reset irq", irq, 0);
    chk("R9 reset drive idle", {drv_oe, drv_dp, drv_dm}, 0);
    rst_n = 1;
    ctl_enable = 1; int_en = 1;
    @(negedge clk);

    // R2 boundary: one tick short, then the completing tick
    ticks(0, 2);
    ticks(2, RST_B - 1);
    chk("R2 short SE0 no reset", st_reset, 0);
    ticks(2, 1);
    chk("R2 reset at limit", st_reset, 1);
    chk("R6 reset sets flag", bus_evt, 1);
    chk("R7 irq with enable", irq, 1);
    int_en = 0; #0;
    @(negedge clk); model_step(); compare();
    chk("R7 irq masked", irq, 0);
    int_en = 1;
    ticks(0, 1);
    chk("R2 reset ends", st_reset, 0);
    bit_en = 0; evt_clr = 1; step(); evt_clr = 0;
    chk("R6 clear flag", bus_evt, 0);

    // R10: SE0 without ticks changes nothing
    set_line(2); bit_en = 0;
    for (int i = 0; i < 3 * RST_B; i++) step();
    chk("R10 no tick no reset", st_reset, 0);
    ticks(0, 1);

    // R5: K cancels the reply timer
    set_line(3); bit_en = 0; resp_arm = 1; step(); resp_arm = 0;
    ticks(3, 10); ticks(1, 1); ticks(3, TOUT_B + 4);
    chk("R5 K cancels timeout", st_timeout, 0);

    // R5/R6: expiry coincides with clear; set wins
    bit_en = 0; resp_arm = 1; step(); resp_arm = 0;
    ticks(3, TOUT_B - 1);
    chk("R5 not yet expired", st_timeout, 0);
    set_line(3); bit_en = 1; evt_clr = 1; step(); evt_clr = 0;
    chk("R5 expired with clear", st_timeout, 1);
    chk("R6 event wins over clear", bus_evt, 1);
    bit_en = 0; evt_clr = 1; step(); evt_clr = 0;
    chk("R6 clear timeout", st_timeout, 0);

    // R3/R4: suspend and resume
    ticks(0, SUSP_B - 1);
    chk("R3 short idle", st_suspend, 0);
    ticks(0, 1);
    chk("R3 suspend at limit", st_suspend, 1);
    ticks(1, 1);
    chk("R3 suspend ends", st_suspend, 0);
    chk("R4 resume set", st_resume, 1);
    bit_en = 0; evt_clr = 1; step(); evt_clr = 0;
    chk("R4 resume cleared", st_resume, 0);

    // R8/R9: overrides
    rwake_req = 1; bit_en = 0; step();
    chk("R8 wake K drive", {drv_oe, drv_dp, drv_dm}, 3'b101);
    force_se0 = 1; step();
    chk("R9 SE0 over wake", {drv_oe, drv_dp, drv_dm}, 3'b100);
    rwake_req = 0; force_se0 = 0; step();
    chk("R9 no override", {drv_oe, drv_dp, drv_dm}, 3'b000);

    // R1: disable clears
    ticks(2, RST_B);
    ctl_enable = 0; bit_en = 0; step(); ctl_enable = 1;
    chk("R1 disable clears reset", st_reset, 0);
    chk("R1 disable clears flag", bus_evt, 0);

    // Random phase against the model
    for (int seg = 0; seg < 400; seg++) begin
      int s, len, r;
      r = $urandom % 10;
      s = (r < 4) ? 0 : (r < 7) ? 1 : (r < 9) ? 2 : 3;
      len = ($urandom % 4 == 0) ? (SUSP_B + ($urandom % 10)) : (1 + $urandom % 12);
      set_line(s);
      for (int i = 0; i < len; i++) begin
        bit_en     = ($urandom % 3) != 0;
        resp_arm   = ($urandom % 30) == 0;
        evt_clr    = ($urandom % 8) == 0;
        ctl_enable = ($urandom % 300) != 0;
        if ($urandom % 20 == 0) int_en = ~int_en;
        rwake_req  = ($urandom % 16) == 0;
        force_se0  = ($urandom % 16) == 0;
        step();
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule